// File: doc/BRIEF.md
# Bus Access Violation Capture Unit

This unit collects reports of illegal bus accesses. Each protected slave raises a one-cycle violation pulse, which sets a sticky status bit. Software clears a status bit by writing one to it. Each slave also has a mask bit. The interrupt line is asserted while the unit is enabled and at least one status bit is set whose mask bit is clear.

Slaves are organised in groups. Each group can hand over the details of one violation: the master ID, the domain ID, the direction and a 36-bit address. The unit latches the first offered record per group and raises a pending flag for that group. Later records for the same group are dropped until software clears the flag.

To read a record, software follows these steps:
1. Select one group with a one-hot value.
2. Start a timed transfer.
3. Poll until the transfer reports done.
4. Read the two shared debug words.
5. Write the transfer register back to idle.

All registers sit behind a single-cycle 12-bit word-aligned port with combinational read data.

Top module: `viol_capture_unit`

## Requirements
- R1: After reset every implemented mask bit reads 1, all status bits read 0, the enable bit, group pending flags, group select and both debug words read 0, the transfer register reads 0, and `irq` is low.
- R2: Slave m is at word m/32, bit m%32. Mask words start at 0x000 and status words start at 0x400, at 4 bytes per word. In the last word, bits at or above `NUM_SLAVES` read 0 and cannot be written. Mask bits are read/write.
- R3: A pulse on `slv_viol[m]` sets status bit m on the next clock. Writing 1 to a status bit clears it. A pulse arriving in the same cycle as a clear of that bit leaves the bit set.
- R4: `irq` equals enable AND (OR over m of status[m] AND NOT mask[m]), with no register between the state and the pin.
- R5: Control register at 0xF00:
  - Writing a word with bit 31 set enables the unit.
  - Writing a word with bit 2 set disables it. Bit 2 wins when both are set.
  - A read returns the enable state in bit 31 and 0 in all other bits.
- R6: Group pending register at 0xF10, one bit per group:
  - When `grp_valid[g]` is high and flag g is clear, the group's record is latched and flag g is set on the next clock.
  - While flag g is set, new records for group g are ignored.
  - Writing 1 to bit g clears flag g, and then the next record is accepted.
- R7: The group select register at 0xF14 stores the low `NUM_GROUPS` bits written and reads them back.
- R8: Transfer register at 0xF20:
  - Writing 1 while it reads 0 makes it read 1. It reads 3 exactly `XFER_CYCLES` clocks after the write edge.
  - Writing 0 returns it to 0 from any state.
  - Writing 1 while it reads 1 or 3 has no effect.
- R9: When a transfer completes, the debug words are updated only if the select value is one-hot.
  - 0x900 holds master ID in [15:0], domain ID in [21:16], a write flag at bit 22, a read flag at bit 23 (the inverse of the write flag), address bits [35:32] in [27:24], and 0 in [31:28].
  - 0x904 holds address bits [31:0].
  - A zero or multi-bit select leaves both words unchanged.
- R10: Reads from an unmapped or non-word-aligned address return 0, including mask or status words at or beyond the last implemented word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| slv_viol | input | NUM_SLAVES | One-cycle violation pulse per slave |
| grp_valid | input | NUM_GROUPS | Violation record offered by each group |
| grp_mid | input | NUM_GROUPS*16 | Master ID per group, group g at [16g+:16] |
| grp_did | input | NUM_GROUPS*6 | Domain ID per group, group g at [6g+:6] |
| grp_wr | input | NUM_GROUPS | 1 for a write violation, 0 for a read |
| grp_addr | input | NUM_GROUPS*36 | Violating address per group, group g at [36g+:36] |
| irq | output | 1 | Interrupt: enabled and any unmasked status bit set |

## Verification
The bench builds the unit with 40 slaves, 4 groups and a 3-cycle transfer.

Forty slaves give one full status word and a partial second word holding 8 live bits. This lets the bench sweep every slave index, including the boundary where unimplemented bits must read 0.

Four groups keep the select field at 4 bits, so all sixteen select codes can be tried. Zero, every one-hot value and every multi-bit value are each checked against the debug words.

The short transfer lets the bench check the busy and done readback on every cycle of each handshake.

// File: rtl/vcu_pkg.sv
package vcu_pkg;

    localparam int MID_W  = 16;
    localparam int DID_W  = 6;
    localparam int ADDR_W = 36;

    localparam logic [11:0] MASK_BASE = 12'h000;
    localparam logic [11:0] STAT_BASE = 12'h400;
    localparam logic [11:0] DBG_LO_A  = 12'h900;
    localparam logic [11:0] DBG_HI_A  = 12'h904;
    localparam logic [11:0] CTRL_A    = 12'hF00;
    localparam logic [11:0] GPEND_A   = 12'hF10;
    localparam logic [11:0] GSEL_A    = 12'hF14;
    localparam logic [11:0] XFER_A    = 12'hF20;

    localparam int CTRL_EN_BIT   = 31;
    localparam int CTRL_STOP_BIT = 2;

    typedef struct packed {
        logic [MID_W-1:0]  mid;
        logic [DID_W-1:0]  did;
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } viol_rec_t;

    typedef enum logic [1:0] {
        XF_IDLE = 2'd0,
        XF_BUSY = 2'd1,
        XF_DONE = 2'd3
    } xfer_state_e;

    function automatic int words_for(int n);
        return (n + 31) / 32;
    endfunction

    function automatic int idx_bits(int nwords);
        return (nwords > 1) ? $clog2(nwords) : 1;
    endfunction

    function automatic logic [31:0] dbg_lo_word(viol_rec_t r);
        return {4'b0, r.addr[35:32], ~r.wr, r.wr, r.did, r.mid};
    endfunction

    function automatic logic is_onehot32(logic [31:0] v);
        return (v != 32'd0) && ((v & (v - 32'd1)) == 32'd0);
    endfunction

endpackage

// File: rtl/vcu_slave_bits.sv
module vcu_slave_bits #(
    parameter int NUM_SLAVES = 40
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic [NUM_SLAVES-1:0]                        viol_i,
    input  logic                                         mask_we,
    input  logic                                         stat_we,
    input  logic [vcu_pkg::idx_bits(vcu_pkg::words_for(NUM_SLAVES))-1:0] wr_idx,
    input  logic [31:0]                                  wdata,
    input  logic [vcu_pkg::idx_bits(vcu_pkg::words_for(NUM_SLAVES))-1:0] rd_idx,
    output logic [31:0]                                  mask_rd,
    output logic [31:0]                                  stat_rd,
    output logic                                         hit_o
);
    localparam int NWORDS = vcu_pkg::words_for(NUM_SLAVES);
    localparam int WIDX_W = vcu_pkg::idx_bits(NWORDS);

    logic [NUM_SLAVES-1:0] mask_q;
    logic [NUM_SLAVES-1:0] stat_q;
    logic [NWORDS*32-1:0]  mask_ext;
    logic [NWORDS*32-1:0]  stat_ext;

    for (genvar s = 0; s < NUM_SLAVES; s++) begin : g_slave
        localparam logic [WIDX_W-1:0] WORD = WIDX_W'(s / 32);
        localparam int                BIT  = s % 32;
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[s] <= 1'b1;
                stat_q[s] <= 1'b0;
            end else begin
                if (mask_we && wr_idx == WORD)
                    mask_q[s] <= wdata[BIT];
                if (viol_i[s])
                    stat_q[s] <= 1'b1;
                else if (stat_we && wr_idx == WORD && wdata[BIT])
                    stat_q[s] <= 1'b0;
            end
        end
    end

    always_comb begin
        mask_ext = '0;
        stat_ext = '0;
        mask_ext[NUM_SLAVES-1:0] = mask_q;
        stat_ext[NUM_SLAVES-1:0] = stat_q;
    end

    assign mask_rd = mask_ext[rd_idx*32 +: 32];
    assign stat_rd = stat_ext[rd_idx*32 +: 32];
    assign hit_o   = |(stat_q & ~mask_q);

endmodule

// File: rtl/vcu_grp_capture.sv
module vcu_grp_capture
    import vcu_pkg::*;
#(
    parameter int NUM_GROUPS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_GROUPS-1:0]      valid_i,
    input  viol_rec_t [NUM_GROUPS-1:0] recs_i,
    input  logic                       clr_we,
    input  logic [NUM_GROUPS-1:0]      clr_bits,
    output logic [NUM_GROUPS-1:0]      pend_o,
    output viol_rec_t [NUM_GROUPS-1:0] recs_o
);
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_o[g] <= 1'b0;
                recs_o[g] <= '0;
            end else if (clr_we && clr_bits[g]) begin
                pend_o[g] <= 1'b0;
            end else if (valid_i[g] && !pend_o[g]) begin
                pend_o[g] <= 1'b1;
                recs_o[g] <= recs_i[g];
            end
        end
    end

endmodule

// File: rtl/vcu_xfer.sv
module vcu_xfer
    import vcu_pkg::*;
#(
    parameter int NUM_GROUPS  = 4,
    parameter int XFER_CYCLES = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ctl_we,
    input  logic [31:0]                ctl_wdata,
    input  logic [NUM_GROUPS-1:0]      sel_i,
    input  viol_rec_t [NUM_GROUPS-1:0] recs_i,
    output xfer_state_e                state_o,
    output logic [31:0]                dbg_lo_o,
    output logic [31:0]                dbg_hi_o
);
    localparam int CNT_W = (XFER_CYCLES > 1) ? $clog2(XFER_CYCLES) : 1;

    logic [CNT_W-1:0] cnt_q;
    viol_rec_t        sel_rec;
    logic             sel_ok;

    always_comb begin
        sel_rec = '0;
        for (int g = 0; g < NUM_GROUPS; g++)
            if (sel_i[g]) sel_rec = sel_rec | recs_i[g];
    end

    assign sel_ok = is_onehot32(32'(sel_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o  <= XF_IDLE;
            cnt_q    <= '0;
            dbg_lo_o <= '0;
            dbg_hi_o <= '0;
        end else if (ctl_we && ctl_wdata == 32'd0) begin
            state_o <= XF_IDLE;
        end else if (ctl_we && ctl_wdata == 32'd1 && state_o == XF_IDLE) begin
            state_o <= XF_BUSY;
            cnt_q   <= CNT_W'(XFER_CYCLES - 1);
        end else if (state_o == XF_BUSY) begin
            if (cnt_q == '0) begin
                state_o <= XF_DONE;
                if (sel_ok) begin
                    dbg_lo_o <= dbg_lo_word(sel_rec);
                    dbg_hi_o <= sel_rec.addr[31:0];
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/viol_capture_unit.sv
module viol_capture_unit
    import vcu_pkg::*;
#(
    parameter int NUM_SLAVES  = 40,
    parameter int NUM_GROUPS  = 4,
    parameter int XFER_CYCLES = 3
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         reg_we,
    input  logic [11:0]                  reg_addr,
    input  logic [31:0]                  reg_wdata,
    output logic [31:0]                  reg_rdata,
    input  logic [NUM_SLAVES-1:0]        slv_viol,
    input  logic [NUM_GROUPS-1:0]        grp_valid,
    input  logic [NUM_GROUPS*MID_W-1:0]  grp_mid,
    input  logic [NUM_GROUPS*DID_W-1:0]  grp_did,
    input  logic [NUM_GROUPS-1:0]        grp_wr,
    input  logic [NUM_GROUPS*ADDR_W-1:0] grp_addr,
    output logic                         irq
);
    localparam int NWORDS = words_for(NUM_SLAVES);
    localparam int WIDX_W = idx_bits(NWORDS);

    logic                       aligned, word_ok, in_mask, in_stat;
    logic [WIDX_W-1:0]          widx;
    logic [31:0]                mask_rd, stat_rd, dbg_lo, dbg_hi;
    logic                       hit, en_q;
    logic [NUM_GROUPS-1:0]      sel_q, grp_pend;
    viol_rec_t [NUM_GROUPS-1:0] recs_in, recs_held;
    xfer_state_e                xst;

    assign aligned = (reg_addr[1:0] == 2'b00);
    assign word_ok = int'(reg_addr[9:2]) < NWORDS;
    assign in_mask = aligned && word_ok && reg_addr[11:10] == MASK_BASE[11:10];
    assign in_stat = aligned && word_ok && reg_addr[11:10] == STAT_BASE[11:10];
    assign widx    = reg_addr[2 +: WIDX_W];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_unpack
        assign recs_in[g] = {grp_mid[g*MID_W +: MID_W], grp_did[g*DID_W +: DID_W],
                             grp_wr[g], grp_addr[g*ADDR_W +: ADDR_W]};
    end

    vcu_slave_bits #(.NUM_SLAVES(NUM_SLAVES)) u_bits (
        .clk(clk), .rst(rst), .viol_i(slv_viol),
        .mask_we(reg_we && in_mask), .stat_we(reg_we && in_stat),
        .wr_idx(widx), .wdata(reg_wdata), .rd_idx(widx),
        .mask_rd(mask_rd), .stat_rd(stat_rd), .hit_o(hit)
    );

    vcu_grp_capture #(.NUM_GROUPS(NUM_GROUPS)) u_grp (
        .clk(clk), .rst(rst), .valid_i(grp_valid), .recs_i(recs_in),
        .clr_we(reg_we && reg_addr == GPEND_A),
        .clr_bits(reg_wdata[NUM_GROUPS-1:0]),
        .pend_o(grp_pend), .recs_o(recs_held)
    );

    vcu_xfer #(.NUM_GROUPS(NUM_GROUPS), .XFER_CYCLES(XFER_CYCLES)) u_xfer (
        .clk(clk), .rst(rst), .ctl_we(reg_we && reg_addr == XFER_A),
        .ctl_wdata(reg_wdata), .sel_i(sel_q), .recs_i(recs_held),
        .state_o(xst), .dbg_lo_o(dbg_lo), .dbg_hi_o(dbg_hi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            sel_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == CTRL_A) begin
                if (reg_wdata[CTRL_STOP_BIT])     en_q <= 1'b0;
                else if (reg_wdata[CTRL_EN_BIT])  en_q <= 1'b1;
            end
            if (reg_addr == GSEL_A) sel_q <= reg_wdata[NUM_GROUPS-1:0];
        end
    end

    assign irq = en_q & hit;

    always_comb begin
        reg_rdata = '0;
        if (in_mask)      reg_rdata = mask_rd;
        else if (in_stat) reg_rdata = stat_rd;
        else begin
            case (reg_addr)
                DBG_LO_A: reg_rdata = dbg_lo;
                DBG_HI_A: reg_rdata = dbg_hi;
                CTRL_A:   reg_rdata = {en_q, 31'b0};
                GPEND_A:  reg_rdata = 32'(grp_pend);
                GSEL_A:   reg_rdata = 32'(sel_q);
                XFER_A:   reg_rdata = {30'b0, xst};
                default:  reg_rdata = '0;
            endcase
        end
    end

endmodule

module vcu_chk #(
    parameter int NUM_GROUPS = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  en_q,
    input logic                  irq,
    input logic [1:0]            xst,
    input logic [31:0]           dbg_lo,
    input logic [31:0]           dbg_hi,
    input logic [NUM_GROUPS-1:0] grp_pend,
    input logic                  reg_we,
    input logic [11:0]           reg_addr,
    input logic                  stop_bit
);
    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !irq);

    // R5
    stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 12'hF00 && stop_bit) |=> !en_q);

    // R6
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == 12'hF10) |=> ((grp_pend & $past(grp_pend)) == $past(grp_pend)));

    // R8
    done_path_chk: assert property (@(posedge clk) disable iff (rst)
        (xst == 2'd3 && $past(xst) != 2'd3) |-> $past(xst) == 2'd1);

    // R9
    dbg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (xst != 2'd1) |=> ($stable(dbg_lo) && $stable(dbg_hi)));

endmodule

bind viol_capture_unit vcu_chk #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
    .clk(clk), .rst(rst), .en_q(en_q), .irq(irq), .xst(xst),
    .dbg_lo(dbg_lo), .dbg_hi(dbg_hi), .grp_pend(grp_pend),
    .reg_we(reg_we), .reg_addr(reg_addr), .stop_bit(reg_wdata[2])
);

// File: tb/viol_capture_unit_bench.sv
`timescale 1ns/100ps
module viol_capture_unit_bench;
    localparam int NS = 40;
    localparam int NG = 4;
    localparam int XC = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [11:0]   reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NS-1:0] slv_viol = '0;
    logic [NG-1:0] grp_valid = '0;
    logic [NG*16-1:0] grp_mid = '0;
    logic [NG*6-1:0]  grp_did = '0;
    logic [NG-1:0]    grp_wr = '0;
    logic [NG*36-1:0] grp_addr = '0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;
    logic [31:0] exp_lo = '0;
    logic [31:0] exp_hi = '0;
    int held_k [NG];

    always #2.5 clk = ~clk;

    viol_capture_unit #(.NUM_SLAVES(NS), .NUM_GROUPS(NG), .XFER_CYCLES(XC)) u_viol_capture_unit (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .slv_viol(slv_viol), .grp_valid(grp_valid), .grp_mid(grp_mid),
        .grp_did(grp_did), .grp_wr(grp_wr), .grp_addr(grp_addr), .irq(irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [15:0] e_mid(int g, int k);
        return 16'(32'h1000 + g * 32'h111 + k * 32'h8000);
    endfunction
    function automatic logic [5:0] e_did(int g, int k);
        return 6'(g + 5 + k * 16);
    endfunction
    function automatic logic e_wr(int g, int k);
        return 1'((g + k) % 2);
    endfunction
    function automatic logic [35:0] e_addr(int g, int k);
        return {4'(g + 9 + k), 32'(32'hA000_0000 + g * 32'h1234 + k * 32'h50)};
    endfunction
    function automatic logic [31:0] e_lo(int g, int k);
        logic [35:0] a;
        a = e_addr(g, k);
        return {4'b0, a[35:32], ~e_wr(g, k), e_wr(g, k), e_did(g, k), e_mid(g, k)};
    endfunction

    task automatic offer(int g, int k);
        @(negedge clk);
        grp_mid[g*16 +: 16] = e_mid(g, k);
        grp_did[g*6 +: 6]   = e_did(g, k);
        grp_wr[g]           = e_wr(g, k);
        grp_addr[g*36 +: 36] = e_addr(g, k);
        grp_valid[g] = 1'b1;
        @(negedge clk);
        grp_valid = '0;
    endtask

    task automatic run_xfer(logic [NG-1:0] sel);
        logic [31:0] d;
        int ones;
        wr(12'hF14, 32'(sel));
        rd(12'hF14, d); chk("R7 select readback", d, 32'(sel));
        wr(12'hF20, 32'd1);
        for (int i = 1; i <= XC; i++) begin
            rd(12'hF20, d);
            chk("R8 transfer busy/done timing", d, (i < XC) ? 32'd1 : 32'd3);
        end
        ones = $countones(sel);
        if (ones == 1) begin
            for (int g = 0; g < NG; g++) if (sel[g]) begin
                exp_lo = e_lo(g, held_k[g]);
                exp_hi = e_addr(g, held_k[g]) >> 0;
            end
        end
        rd(12'h900, d); chk("R9 debug word 0", d, exp_lo);
        rd(12'h904, d); chk("R9 debug word 1", d, exp_hi);
        wr(12'hF20, 32'd1);
        rd(12'hF20, d); chk("R8 start while done ignored", d, 32'd3);
        wr(12'hF20, 32'd0);
        rd(12'hF20, d); chk("R8 stop returns idle", d, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(12'h000, rv); chk("R1 mask word0 reset", rv, 32'hFFFF_FFFF);
        rd(12'h004, rv); chk("R1 mask word1 reset", rv, 32'h0000_00FF);
        rd(12'h400, rv); chk("R1 status word0 reset", rv, 32'h0);
        rd(12'h404, rv); chk("R1 status word1 reset", rv, 32'h0);
        rd(12'hF00, rv); chk("R1 ctrl reset", rv, 32'h0);
        rd(12'hF10, rv); chk("R1 pending reset", rv, 32'h0);
        rd(12'hF14, rv); chk("R1 select reset", rv, 32'h0);
        rd(12'hF20, rv); chk("R1 transfer reset", rv, 32'h0);
        rd(12'h900, rv); chk("R1 debug0 reset", rv, 32'h0);
        rd(12'h904, rv); chk("R1 debug1 reset", rv, 32'h0);
        chk("R1 irq reset", 32'(irq), 32'd0);

        // R10 unmapped reads
        rd(12'h008, rv); chk("R10 mask beyond last word", rv, 32'h0);
        rd(12'h408, rv); chk("R10 status beyond last word", rv, 32'h0);
        rd(12'h800, rv); chk("R10 hole", rv, 32'h0);
        rd(12'hF04, rv); chk("R10 hole near ctrl", rv, 32'h0);
        rd(12'hF02, rv); chk("R10 unaligned", rv, 32'h0);

        // R5 enable
        wr(12'hF00, 32'h8000_0000);
        rd(12'hF00, rv); chk("R5 enable readback", rv, 32'h8000_0000);

        // R2 mask read/write, partial last word
        wr(12'h000, 32'h0); wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, rv); chk("R2 mask last word only low bits", rv, 32'h0000_00FF);
        wr(12'h004, 32'h0);
        rd(12'h000, rv); chk("R2 mask word0 cleared", rv, 32'h0);
        rd(12'h004, rv); chk("R2 mask word1 cleared", rv, 32'h0);

        // R2 R3 R4 sweep every slave
        for (int m = 0; m < NS; m++) begin
            logic [11:0] so, mo, oo;
            so = 12'(32'h400 + (m / 32) * 4);
            mo = 12'((m / 32) * 4);
            oo = 12'(32'h400 + (1 - m / 32) * 4);
            @(negedge clk); slv_viol[m] = 1'b1;
            @(negedge clk); slv_viol = '0;
            rd(so, rv); chk("R2 R3 status bit position", rv, 32'h1 << (m % 32));
            rd(oo, rv); chk("R2 other status word empty", rv, 32'h0);
            chk("R4 irq with unmasked status", 32'(irq), 32'd1);
            wr(mo, 32'h1 << (m % 32));
            #1 chk("R4 irq masked", 32'(irq), 32'd0);
            wr(mo, 32'h0);
            wr(so, 32'h1 << (m % 32));
            rd(so, rv); chk("R3 write-one clears", rv, 32'h0);
            chk("R4 irq after clear", 32'(irq), 32'd0);
        end

        // R3 set wins over clear
        @(negedge clk);
        slv_viol[5] = 1'b1; reg_we = 1'b1; reg_addr = 12'h400; reg_wdata = 32'h20;
        @(negedge clk);
        slv_viol = '0; reg_we = 1'b0;
        rd(12'h400, rv); chk("R3 set beats clear", rv, 32'h20);

        // R4 R5 enable gating
        chk("R4 irq pending", 32'(irq), 32'd1);
        wr(12'hF00, 32'h0000_0004);
        #1 chk("R4 irq gated by disable", 32'(irq), 32'd0);
        rd(12'hF00, rv); chk("R5 stop readback", rv, 32'h0);
        wr(12'hF00, 32'h8000_0004);
        rd(12'hF00, rv); chk("R5 stop wins over enable", rv, 32'h0);
        wr(12'hF00, 32'h8000_0000);
        #1 chk("R4 irq after re-enable", 32'(irq), 32'd1);
        wr(12'h400, 32'h20);
        #1 chk("R4 irq cleared", 32'(irq), 32'd0);

        // R6 group capture
        for (int g = 0; g < NG; g++) begin
            offer(g, 0);
            held_k[g] = 0;
            rd(12'hF10, rv); chk("R6 pending accumulates", rv, (32'h1 << (g + 1)) - 1);
        end
        offer(0, 1);
        rd(12'hF10, rv); chk("R6 pending unchanged by drop", rv, 32'hF);

        // R7 R8 R9 every select code
        for (int s = 0; s < 16; s++) run_xfer(4'(s));

        // R6 clear and recapture
        wr(12'hF10, 32'h5);
        rd(12'hF10, rv); chk("R6 write-one clears pending", rv, 32'hA);
        offer(0, 1);
        held_k[0] = 1;
        rd(12'hF10, rv); chk("R6 recapture after clear", rv, 32'hB);
        run_xfer(4'b0001);
        run_xfer(4'b0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule